// File: doc/BRIEF.md
# Pulse-Response Equalizer Tap Extractor

This block measures the feedback tap weights of a decision feedback equalizer from a single sampled pulse response, without any adaptive loop. A start request launches one measurement. The block first averages eight symbol-rate samples of the idle line, which sits at the low level. It then raises a one-cycle request to the stimulus source, which sends one isolated pulse lasting exactly one symbol. The block then watches the following samples.

Each sample arrives with a strobe from the symbol-rate sampling clock. The phase of that clock comes from a programmable delay value, which the block latches and holds for the sampling-clock generator. A sample counts as a cursor when its distance from the measured baseline is greater than a programmable threshold. Cursors are assigned by order of appearance. The first is the pre-cursor, the second is the main cursor, and each later one is the next post-cursor tap. Every tap is reported as the sample minus the baseline.

The run ends when all post-cursor taps are filled or when a strobe timeout expires. A one-cycle done flag marks the end. The results then stay unchanged until the next accepted start.

Top module: `dfe_tap_extract`

## Requirements
- R1: While reset is held and after it is released, busy, done and pulseReq are low, and baseline, preTap, mainTap and postTaps are all zero.
- R2: A start seen while idle makes busy high on the next cycle and latches phaseCfg onto samplePhase. While busy, start is ignored: samplePhase keeps its value and the run is not restarted.
- R3: The baseline is the arithmetic mean of the first 8 strobed samples after start, rounded toward minus infinity (the sum shifted right arithmetically by 3).
- R4: pulseReq is high for exactly one cycle, namely the cycle right after the clock edge that takes the 8th baseline sample. The block takes no samples during that cycle.
- R5: A strobed sample is a cursor only when |sample − baseline| is strictly greater than the threshold latched at start. A distance equal to the threshold does not count.
- R6: Cursors are stored in order of appearance: the 1st in preTap, the 2nd in mainTap, and the 3rd, 4th and so on in post-tap slot 0, 1, and so on. Post-tap slot k occupies postTaps bits [13k+12:13k]. Every stored value is the signed 13-bit result of sample − baseline.
- R7: Once N_POST post-cursor taps are stored, the block stops capturing and done pulses for one cycle. After that pulse busy is low.
- R8: If TIMEOUT (64) strobes arrive while cursors are being hunted, capture ends and done pulses. Slots that were not filled read zero.
- R9: While idle without a start, all tap outputs hold their values. An accepted start clears them to zero on the next cycle.
- R10: A sample presented while sampleValid is low has no effect on the baseline or on any tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Measurement request, taken only while idle |
| phaseCfg | input | 6 | Sampling-phase delay setting, latched at start |
| thrCfg | input | 12 | Cursor detection threshold, latched at start |
| sampleValid | input | 1 | Strobe from the symbol-rate sampling clock |
| sampleIn | input | 12 | Signed line sample |
| pulseReq | output | 1 | One-cycle request to launch the single-symbol pulse |
| samplePhase | output | 6 | Latched phase delay for the sampling-clock generator |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle end-of-measurement flag |
| baseline | output | 12 | Measured low-level reference |
| preTap | output | 13 | Pre-cursor value relative to the baseline |
| mainTap | output | 13 | Main-cursor value relative to the baseline |
| postTaps | output | 52 | Post-cursor taps h1 to h4, 13 bits each, h1 in the low bits |

## Verification
The hardest situation to reach from the ports is a run that stops on the timeout after only some of the post-cursor slots are filled. To get there, the stimulus must produce a partial run whose cursors include a negative tap and a sample that lies exactly at the threshold distance. The bench sets up such a response on a baseline whose eight samples do not sum to a multiple of eight, so the floor rounding of the average decides which samples count. It then keeps the line near the baseline until 64 hunting strobes have passed. Other cases send junk values between strobes and issue a second start while a run is under way, to show that neither has any effect.

// File: rtl/dfe_tap_pkg.sv
package dfe_tap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_LAUNCH,
    ST_HUNT,
    ST_DONE
  } extState_t;

  typedef struct packed {
    logic clear;     // accepted start: reset run state, latch config
    logic accEn;     // accumulate a baseline sample
    logic baseLoad;  // last baseline sample: store the average
    logic huntEn;    // strobed sample during cursor hunt
  } dpCtrl_t;
endpackage

// File: rtl/dfe_tap_ctrl.sv
module dfe_tap_ctrl
  import dfe_tap_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int TIMEOUT   = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    sampleValid,
  input  logic    postFull,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done,
  output logic    pulseReq
);
  localparam int TOW = $clog2(TIMEOUT + 1);
  localparam logic [BASE_LOG2-1:0] BASE_LAST = {BASE_LOG2{1'b1}};
  localparam logic [TOW-1:0] TO_LAST = TOW'(TIMEOUT - 1);

  extState_t state, stateNext;
  logic [BASE_LOG2-1:0] baseCnt;
  logic [TOW-1:0] timer;

  always_comb begin
    ctrl = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.clear = 1'b1;
          stateNext = ST_BASE;
        end
      end
      ST_BASE: begin
        ctrl.accEn = sampleValid;
        if (sampleValid && baseCnt == BASE_LAST) begin
          ctrl.baseLoad = 1'b1;
          stateNext = ST_LAUNCH;
        end
      end
      ST_LAUNCH: stateNext = ST_HUNT;
      ST_HUNT: begin
        if (postFull) begin
          stateNext = ST_DONE;
        end else begin
          ctrl.huntEn = sampleValid;
          if (sampleValid && timer == TO_LAST) stateNext = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      baseCnt <= '0;
      timer   <= '0;
    end else begin
      state <= stateNext;
      if (ctrl.clear) begin
        baseCnt <= '0;
        timer   <= '0;
      end else begin
        if (ctrl.accEn) baseCnt <= baseCnt + 1'b1;
        if (ctrl.huntEn) timer <= timer + 1'b1;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign pulseReq = (state == ST_LAUNCH);
endmodule

// File: rtl/dfe_tap_dp.sv
module dfe_tap_dp
  import dfe_tap_pkg::*;
#(
  parameter int SW        = 12,
  parameter int NPOST     = 4,
  parameter int BASE_LOG2 = 3,
  parameter int PW        = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctrl,
  input  logic signed [SW-1:0]     sampleIn,
  input  logic [SW-1:0]            thrCfg,
  input  logic [PW-1:0]            phaseCfg,
  output logic signed [SW-1:0]     baseline,
  output logic signed [SW:0]       preTap,
  output logic signed [SW:0]       mainTap,
  output logic [NPOST*(SW+1)-1:0]  postTaps,
  output logic                     postFull,
  output logic [PW-1:0]            samplePhase
);
  localparam int AW    = SW + BASE_LOG2;
  localparam int TW    = SW + 1;
  localparam int SLOTS = NPOST + 2;
  localparam int IW    = $clog2(SLOTS + 1);

  logic signed [AW-1:0] acc, accSum, avg;
  logic signed [TW-1:0] diff;
  logic [TW-1:0] mag;
  logic [SW-1:0] thrLat;
  logic [IW-1:0] idx;
  logic hit;
  logic signed [TW-1:0] slot [SLOTS];

  assign accSum = acc + AW'(sampleIn);
  assign avg    = accSum >>> BASE_LOG2;
  assign diff   = TW'(sampleIn) - TW'(baseline);
  assign mag    = diff[TW-1] ? TW'(-diff) : TW'(diff);
  assign hit    = mag > {1'b0, thrLat};
  assign postFull = (idx == IW'(SLOTS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      baseline    <= '0;
      thrLat      <= '0;
      samplePhase <= '0;
      idx         <= '0;
      for (int k = 0; k < SLOTS; k++) slot[k] <= '0;
    end else if (ctrl.clear) begin
      acc         <= '0;
      baseline    <= '0;
      thrLat      <= thrCfg;
      samplePhase <= phaseCfg;
      idx         <= '0;
      for (int k = 0; k < SLOTS; k++) slot[k] <= '0;
    end else begin
      if (ctrl.accEn) acc <= accSum;
      if (ctrl.baseLoad) baseline <= avg[SW-1:0];
      if (ctrl.huntEn && hit && !postFull) begin
        idx <= idx + 1'b1;
        for (int k = 0; k < SLOTS; k++)
          if (IW'(k) == idx) slot[k] <= diff;
      end
    end
  end

  assign preTap  = slot[0];
  assign mainTap = slot[1];

  for (genvar g = 0; g < NPOST; g++) begin : gPost
    assign postTaps[g*TW +: TW] = slot[g+2];
  end
endmodule

// File: rtl/dfe_tap_extract.sv
module dfe_tap_extract
  import dfe_tap_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int N_POST    = 4,
  parameter int TIMEOUT   = 64,
  parameter int PHASE_W   = 6,
  parameter int BASE_LOG2 = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic [PHASE_W-1:0]               phaseCfg,
  input  logic [SAMPLE_W-1:0]              thrCfg,
  input  logic                             sampleValid,
  input  logic signed [SAMPLE_W-1:0]       sampleIn,
  output logic                             pulseReq,
  output logic [PHASE_W-1:0]               samplePhase,
  output logic                             busy,
  output logic                             done,
  output logic signed [SAMPLE_W-1:0]       baseline,
  output logic signed [SAMPLE_W:0]         preTap,
  output logic signed [SAMPLE_W:0]         mainTap,
  output logic [N_POST*(SAMPLE_W+1)-1:0]   postTaps
);
  dpCtrl_t ctrl;
  logic postFull;

  dfe_tap_ctrl #(.BASE_LOG2(BASE_LOG2), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
    .postFull(postFull), .ctrl(ctrl), .busy(busy), .done(done),
    .pulseReq(pulseReq)
  );

  dfe_tap_dp #(.SW(SAMPLE_W), .NPOST(N_POST), .BASE_LOG2(BASE_LOG2),
               .PW(PHASE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sampleIn(sampleIn),
    .thrCfg(thrCfg), .phaseCfg(phaseCfg), .baseline(baseline),
    .preTap(preTap), .mainTap(mainTap), .postTaps(postTaps),
    .postFull(postFull), .samplePhase(samplePhase)
  );
endmodule

// File: rtl/dfe_tap_chk.sv
module dfe_tap_chk #(
  parameter int TW    = 13,
  parameter int NPOST = 4,
  parameter int PW    = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic                  pulseReq,
  input logic [PW-1:0]         samplePhase,
  input logic [TW-1:0]         preTap,
  input logic [TW-1:0]         mainTap,
  input logic [NPOST*TW-1:0]   postTaps
);
  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_phase_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(samplePhase));

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    pulseReq |=> !pulseReq);

  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(preTap) && $stable(mainTap) && $stable(postTaps)));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (preTap == '0 && mainTap == '0 && postTaps == '0));
endmodule

bind dfe_tap_extract dfe_tap_chk #(
  .TW(SAMPLE_W + 1), .NPOST(N_POST), .PW(PHASE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .pulseReq(pulseReq), .samplePhase(samplePhase), .preTap(preTap),
  .mainTap(mainTap), .postTaps(postTaps)
);

// File: tb/tb_dfe_tap_extract.sv
module tb_dfe_tap_extract;
  localparam int NV = 5;
  localparam int NPOST = 4;
  localparam int TO = 64;
  localparam int TW = 13;

  localparam int VEC [0:NV-1][0:19] = '{
    '{-1000,-1000,-1000,-1000,-1000,-1000,-1000,-1000,
      -1000,-990,-800,1000,0,-500,-1000,-900,-940,-1000,-1000,-1000},
    '{-1000,-1001,-1003,-998,-1000,-1002,-999,-1000,
      -981,-980,900,300,-1022,-1001,-990,-1001,-1001,-1001,-1001,-1001},
    '{-512,-512,-512,-512,-512,-512,-512,-512,
      -512,-511,700,-512,100,50,-100,-200,-512,-512,-512,-512},
    '{-2048,-2048,-2048,-2048,-2048,-2048,-2048,-2048,
      -2048,2047,2047,-1900,-1948,-1947,0,1000,-2048,-2048,-2048,-2048},
    '{-700,-700,-700,-700,-700,-700,-700,-700,
      -700,-700,-700,-700,-700,-700,-700,-700,-700,-700,-700,-700}
  };
  localparam int THR [0:NV-1] = '{50, 20, 0, 100, 30};
  localparam bit CONT [0:NV-1] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [5:0] phaseCfg = '0;
  logic [11:0] thrCfg = '0;
  logic sampleValid = 1'b0;
  logic signed [11:0] sampleIn = '0;
  logic pulseReq, busy, done;
  logic [5:0] samplePhase;
  logic signed [11:0] baseline;
  logic signed [12:0] preTap, mainTap;
  logic [NPOST*TW-1:0] postTaps;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dfe_tap_extract dut (
    .clk(clk), .rstN(rstN), .start(start), .phaseCfg(phaseCfg),
    .thrCfg(thrCfg), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .pulseReq(pulseReq), .samplePhase(samplePhase), .busy(busy),
    .done(done), .baseline(baseline), .preTap(preTap), .mainTap(mainTap),
    .postTaps(postTaps)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int postAt(input int k);
    logic signed [TW-1:0] v;
    v = postTaps[k*TW +: TW];
    return int'(v);
  endfunction

  function automatic int huntSample(input int r, input int j);
    return (j < 12) ? VEC[r][8+j] : VEC[r][0];
  endfunction

  task automatic doRun(input int r, input bit busyStart);
    int expBase, sum, idx, d, mag, n;
    int expSlot [0:NPOST+1];
    bit doneSeen;
    bit cont;
    cont = CONT[r];
    // expected results from the requirements
    sum = 0;
    for (int i = 0; i < 8; i++) sum += VEC[r][i];
    expBase = sum >>> 3;
    for (int k = 0; k < NPOST + 2; k++) expSlot[k] = 0;
    idx = 0;
    for (int j = 0; j < TO; j++) begin
      if (idx == NPOST + 2) break;
      d = huntSample(r, j) - expBase;
      mag = (d < 0) ? -d : d;
      if (mag > THR[r]) begin
        expSlot[idx] = d;
        idx++;
      end
    end

    @(negedge clk);
    phaseCfg = 6'(r + 5);
    thrCfg = 12'(THR[r]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(samplePhase == 6'(r + 5), "R2 phase latched", int'(samplePhase), r + 5);
    chk(preTap == 0 && mainTap == 0 && postTaps == '0, "R9 start clears taps",
        int'(preTap), 0);

    // baseline window; junk between strobes in gap mode (R10)
    for (int i = 0; i < 8; i++) begin
      sampleValid = 1'b1;
      sampleIn = 12'(VEC[r][i]);
      @(negedge clk);
      if (i < 7) chk(pulseReq == 1'b0, "R4 no early pulse request", int'(pulseReq), 0);
      if (i == 7 || !cont) begin
        sampleValid = 1'b0;
        sampleIn = 12'sd2047;
      end
      if (i == 7) begin
        chk(pulseReq == 1'b1, "R4 pulse request after 8th sample", int'(pulseReq), 1);
        chk(int'(baseline) == expBase, "R3 baseline average", int'(baseline), expBase);
      end else if (!cont) begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    chk(pulseReq == 1'b0, "R4 pulse request one cycle", int'(pulseReq), 0);

    // cursor hunt
    doneSeen = 1'b0;
    n = 0;
    while (!doneSeen && n < TO + 16) begin
      sampleValid = 1'b1;
      sampleIn = 12'(huntSample(r, n));
      @(negedge clk);
      n++;
      if (done) doneSeen = 1'b1;
      if (!cont && !doneSeen) begin
        sampleValid = 1'b0;
        sampleIn = 12'sd2047;
        if (busyStart && n == 2) begin
          start = 1'b1;
          phaseCfg = 6'd63;
        end
        @(negedge clk);
        start = 1'b0;
        if (done) doneSeen = 1'b1;
      end
    end
    sampleValid = 1'b0;
    sampleIn = 12'sd2047;
    chk(doneSeen, (idx == NPOST + 2) ? "R7 done after all taps" : "R8 done on timeout",
        int'(doneSeen), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 done single cycle then idle", int'(done), 0);
    chk(samplePhase == 6'(r + 5), "R2 phase unchanged by busy start", int'(samplePhase), r + 5);
    chk(int'(preTap) == expSlot[0], "R6 pre-cursor", int'(preTap), expSlot[0]);
    chk(int'(mainTap) == expSlot[1], "R6 main cursor", int'(mainTap), expSlot[1]);
    for (int k = 0; k < NPOST; k++)
      chk(postAt(k) == expSlot[k+2],
          (idx == NPOST + 2) ? "R6 post tap" : "R8 post tap after timeout",
          postAt(k), expSlot[k+2]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int keepPre, keepMain, keepPost0;
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0 && pulseReq == 0, "R1 control low in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && pulseReq == 0, "R1 control low after reset", int'(done), 0);
    chk(baseline == 0 && preTap == 0 && mainTap == 0 && postTaps == '0,
        "R1 outputs zero after reset", int'(preTap), 0);

    // vector table: R3 floor average, R5 threshold equality, R6 order,
    // R8 partial timeout, R10 junk between strobes, R2 start while busy
    for (int r = 0; r < NV; r++) doRun(r, r == 0);

    // R9: idle hold with strobes, junk and a new threshold but no start
    keepPre = int'(preTap);
    keepMain = int'(mainTap);
    keepPost0 = postAt(0);
    run3Again();
    chk(int'(preTap) == keepPre && int'(mainTap) == keepMain && postAt(0) == keepPost0,
        "R9 taps held while idle", int'(preTap), keepPre);

    // new start clears, then full run again on a non-zero response
    doRun(0, 1'b0);
    doRun(4, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run3Again();
    for (int i = 0; i < 10; i++) begin
      sampleValid = i[0];
      sampleIn = 12'sd1500;
      thrCfg = 12'd1;
      @(negedge clk);
      chk(busy == 1'b0, "R9 stays idle without start", int'(busy), 0);
    end
    sampleValid = 1'b0;
  endtask
endmodule